// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic read and write a 32768 x 8 asynchronous static RAM. The host side is a level request with a read/write flag, a 15-bit word address and a write byte. The host holds the request until the controller answers with a single-cycle done pulse. On a read, the returned byte is presented together with that pulse. The memory side carries the active-low chip select, write strobe and output-enable strobe, plus the address bus. The shared data bus is split into an outgoing byte, a drive enable for the tristate buffer at the pad, and an incoming byte.

Every phase of an access lasts a whole number of clock cycles, counted by a small phase timer. Each phase length is a parameter, set to cover the memory's nanosecond minimums at a 100 MHz clock:

- A read opens the outputs for four cycles and captures the bus in the last of them.
- A write holds the write strobe low for three cycles.
- The controller drives the data bus from one cycle before the write strobe falls until one cycle after it rises. During the whole write, the output enable stays high.
- After every read, two cycles with the output enable high pass before the controller may drive the bus again. This covers the time the memory may keep driving after its strobes release.

Top module: `sram_access_ctrl`

## Requirements
- R1: After reset and while no access is in progress:
  - chip select, write strobe and output enable are all high (1);
  - the data drive enable is low;
  - done is low;
  - read data is 0.
- R2: A read holds chip select and output enable low, with the write strobe high, for exactly RD_CYC (default 4) consecutive cycles. The read data output then equals the byte on the incoming data bus in the last of those cycles.
- R3: A write holds the write strobe low for exactly WR_CYC (default 3) consecutive cycles. In every one of those cycles, chip select is low and output enable is high.
- R4: The data drive enable is high in the cycle before the write strobe falls, in every cycle it is low, and in the cycle after it rises. The driven byte then equals the requested write data.
- R5: The data drive enable is never high in a cycle where output enable is low.
- R6: The data drive enable rises only after output enable has been high for at least TURN_CYC (default 2) full cycles.
- R7: A request is accepted only when the controller is idle and done is low. Done is high for exactly one cycle per access:
  - for a read, in the cycle after the last output-enable-low cycle;
  - for a write, in the cycle after the post-strobe hold cycle.
  A request still held during the done cycle does not start a second access.
- R8: The read data output keeps its value from one read's done pulse until the next read completes. Writes in between leave it unchanged.
- R9: While chip select is low, the memory address is constant and equals the address of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request, held until done |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 15 | Word address |
| wdata_i | input | 8 | Write byte |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last read byte |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | 15 | Memory address |
| mem_dq_o | output | 8 | Byte driven onto the data bus |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 8 | Byte read from the data bus |

## Verification
The bench's memory model returns valid data only from the fourth cycle of the output-enable-low window. A controller that samples one cycle early would therefore return a filler byte and miscompare against the write scoreboard.

Writes issued straight after reads exercise the bus turnaround. A controller that shortened the output-enable-high gap, or drove the bus while the memory's outputs were open, would be flagged on the cycle where the drive enable rises.

The bench keeps the request high through the done cycle. A controller that ignored done when accepting would start a second, phantom write. Reads separated by writes show whether the read data output is wrongly disturbed between reads.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RD_STROBE = 3'd1,
    ST_RD_TURN   = 3'd2,
    ST_WR_SETUP  = 3'd3,
    ST_WR_STROBE = 3'd4,
    ST_WR_HOLD   = 3'd5
  } seq_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

  function automatic strobe_t strobe_decode(seq_state_e st);
    strobe_t s;
    s = STROBE_IDLE;
    case (st)
      ST_RD_STROBE: begin
        s.ce_n = 1'b0;
        s.oe_n = 1'b0;
      end
      ST_WR_SETUP, ST_WR_HOLD: begin
        s.ce_n  = 1'b0;
        s.drive = 1'b1;
      end
      ST_WR_STROBE: begin
        s.ce_n  = 1'b0;
        s.we_n  = 1'b0;
        s.drive = 1'b1;
      end
      default: s = STROBE_IDLE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC   = 4,
  parameter int unsigned WR_CYC   = 3,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_i,
  input  logic    wr_i,
  output logic    accept_o,
  output logic    capture_o,
  output logic    done_o,
  output strobe_t strobe_o
);

  localparam int unsigned MAX_RW  = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int unsigned MAX_CYC = (MAX_RW > TURN_CYC) ? MAX_RW : TURN_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  seq_state_e       state_q, state_d;
  strobe_t          strobe_q;
  logic             done_q, done_d;
  logic             tmr_clr;
  logic             tmr_en;
  logic [CNT_W-1:0] tmr_cnt;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (tmr_en),
    .clr_i (tmr_clr),
    .cnt_o (tmr_cnt)
  );

  assign tmr_en = (state_q != ST_IDLE) || tmr_clr;

  always_comb begin
    state_d   = state_q;
    tmr_clr   = 1'b0;
    accept_o  = 1'b0;
    capture_o = 1'b0;
    done_d    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_i && !done_q) begin
          accept_o = 1'b1;
          tmr_clr  = 1'b1;
          state_d  = wr_i ? ST_WR_SETUP : ST_RD_STROBE;
        end
      end
      ST_RD_STROBE: begin
        if (tmr_cnt == RD_LAST) begin
          capture_o = 1'b1;
          done_d    = 1'b1;
          tmr_clr   = 1'b1;
          state_d   = ST_RD_TURN;
        end
      end
      ST_RD_TURN: begin
        if (tmr_cnt == TURN_LAST) begin
          tmr_clr = 1'b1;
          state_d = ST_IDLE;
        end
      end
      ST_WR_SETUP: begin
        tmr_clr = 1'b1;
        state_d = ST_WR_STROBE;
      end
      ST_WR_STROBE: begin
        if (tmr_cnt == WR_LAST) begin
          tmr_clr = 1'b1;
          state_d = ST_WR_HOLD;
        end
      end
      ST_WR_HOLD: begin
        tmr_clr = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: begin
        tmr_clr = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      strobe_q <= STROBE_IDLE;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      strobe_q <= strobe_decode(state_d);
      done_q   <= done_d;
    end
  end

  assign done_o   = done_q;
  assign strobe_o = strobe_q;

endmodule

// File: rtl/sram_bus_path.sv
module sram_bus_path #(
  parameter int unsigned AW = 15,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] mem_dq_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic [DW-1:0] rdata_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture_i) begin
      rdata_q <= mem_dq_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wdata_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/sram_access_ctrl.sv
module sram_access_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW       = 15,
  parameter int unsigned DW       = 8,
  parameter int unsigned RD_CYC   = 4,
  parameter int unsigned WR_CYC   = 3,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          mem_ce_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  strobe_t strobe;
  logic    accept;
  logic    capture;

  sram_seq_fsm #(
    .RD_CYC   (RD_CYC),
    .WR_CYC   (WR_CYC),
    .TURN_CYC (TURN_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .wr_i      (wr_i),
    .accept_o  (accept),
    .capture_o (capture),
    .done_o    (done_o),
    .strobe_o  (strobe)
  );

  sram_bus_path #(
    .AW (AW),
    .DW (DW)
  ) u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .mem_dq_i   (mem_dq_i),
    .mem_addr_o (mem_addr_o),
    .mem_dq_o   (mem_dq_o),
    .rdata_o    (rdata_o)
  );

  assign mem_ce_n_o  = strobe.ce_n;
  assign mem_we_n_o  = strobe.we_n;
  assign mem_oe_n_o  = strobe.oe_n;
  assign mem_dq_oe_o = strobe.drive;

endmodule

// File: rtl/sram_access_ctrl_chk.sv
module sram_access_ctrl_chk #(
  parameter int unsigned AW       = 15,
  parameter int unsigned DW       = 8,
  parameter int unsigned TURN_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done_o,
  input logic [DW-1:0] rdata_o,
  input logic          mem_ce_n_o,
  input logic          mem_we_n_o,
  input logic          mem_oe_n_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_dq_oe_o
);

  localparam int unsigned HW = $clog2(TURN_CYC + 1) + 1;
  localparam logic [HW-1:0] HI_SAT = HW'(TURN_CYC);

  logic [HW-1:0] oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_hi_cnt <= HI_SAT;
    end else if (!mem_oe_n_o) begin
      oe_hi_cnt <= '0;
    end else if (oe_hi_cnt != HI_SAT) begin
      oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe_o |-> mem_oe_n_o);

  p_write_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> (mem_oe_n_o && !mem_ce_n_o));

  p_drive_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n_o |-> mem_dq_oe_o);

  p_drive_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n_o) |-> $past(mem_dq_oe_o));

  p_drive_trail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n_o) |-> mem_dq_oe_o);

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe_o) |-> (oe_hi_cnt >= HI_SAT));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(rdata_o));

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(
  .AW       (AW),
  .DW       (DW),
  .TURN_CYC (TURN_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_access_ctrl_tb_top.sv
module sram_access_ctrl_tb_top;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int RD_CYC = 4;
  localparam int WR_CYC = 3;
  localparam int TURN_CYC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          done;
  logic [DW-1:0] rdata;
  logic          ce_n, we_n, oe_n, dq_oe;
  logic [AW-1:0] maddr;
  logic [DW-1:0] dq_o;
  logic [DW-1:0] dq_i = 8'hEE;

  always #4 clk = ~clk;

  sram_access_ctrl #(
    .AW(AW), .DW(DW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .done_o(done), .rdata_o(rdata), .mem_ce_n_o(ce_n), .mem_we_n_o(we_n),
    .mem_oe_n_o(oe_n), .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe),
    .mem_dq_i(dq_i)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit ended = 1'b0;

  logic [7:0] dev_mem [int];
  logic [7:0] exp_mem [int];
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wdata = '0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  // Memory model and cycle-by-cycle bus monitor
  logic          p_we = 1'b1, p_oe = 1'b1, p_ce = 1'b1, p_dq = 1'b0;
  logic [AW-1:0] p_addr = '0;
  int we_run = 0, oe_run = 0, oe_hi = 100;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe) check(oe_n, "R5 drive while outputs open", oe_n, 1);
      if (!we_n) check(oe_n && !ce_n && dq_oe, "R3/R4 strobe state in write", {ce_n, oe_n, dq_oe}, 3'b011);
      if (!we_n && p_we) check(p_dq, "R4 drive before write strobe", p_dq, 1);
      if (!we_n) we_run++;
      if (we_n && !p_we) begin
        check(we_run == WR_CYC, "R3 write strobe width", we_run, WR_CYC);
        check(dq_oe && dq_o == cur_wdata, "R4 driven data after strobe", {dq_oe, dq_o}, {1'b1, cur_wdata});
        dev_mem[int'(maddr)] = dq_o;
        we_run = 0;
      end
      if (!oe_n) begin
        oe_run++;
        oe_hi = 0;
        if (oe_run == 1) check(we_n && !ce_n, "R2 strobes during read", {we_n, ce_n}, 2'b10);
        if (oe_run >= RD_CYC)
          dq_i = dev_mem.exists(int'(maddr)) ? dev_mem[int'(maddr)] : 8'h00;
        else
          dq_i = 8'hEE;
      end else begin
        if (oe_hi < 100) oe_hi++;
        dq_i = 8'hEE;
        if (!p_oe) begin
          check(oe_run == RD_CYC, "R2 output enable width", oe_run, RD_CYC);
          oe_run = 0;
        end
      end
      if (dq_oe && !p_dq) check(oe_hi >= TURN_CYC + 1, "R6 turnaround before drive", oe_hi, TURN_CYC + 1);
      if (!ce_n && !p_ce) check(maddr == p_addr, "R9 address stable", maddr, p_addr);
      if (!ce_n && p_ce) check(maddr == cur_addr, "R9 address matches request", maddr, cur_addr);
      p_we = we_n; p_oe = oe_n; p_ce = ce_n; p_dq = dq_oe; p_addr = maddr;
    end
  end

  task automatic access(input bit is_wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] exp;
    int waits;
    req = 1'b1; wr = is_wr; addr = a; wdata = d;
    cur_addr = a; cur_wdata = d;
    if (is_wr) exp_mem[int'(a)] = d;
    exp = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 8'h00;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!done && waits < 40);
    check(done, "R7 done arrives", done, 1);
    if (!is_wr) check(rdata == exp, "R2 read data", rdata, exp);
    @(negedge clk);
    check(!done && ce_n, "R7 one-cycle done, no second access", {done, ce_n}, 2'b01);
    req = 1'b0;
  endtask

  function automatic logic [AW-1:0] pool_addr(input int i);
    if (i == 0) return '0;
    if (i == 15) return {AW{1'b1}};
    return AW'(i * 2047);
  endfunction

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !done && rdata == 0, "R1 reset state",
          {ce_n, we_n, oe_n, dq_oe, done}, 5'b11100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !done, "R1 idle with no request",
          {ce_n, we_n, oe_n, dq_oe, done}, 5'b11100);

    for (int i = 0; i < 16; i++) access(1'b1, pool_addr(i), DW'(8'h11 * i + 3));
    access(1'b1, pool_addr(15), 8'hA5);
    access(1'b0, pool_addr(15), 8'h00);
    access(1'b1, pool_addr(0), 8'h5A);
    access(1'b0, pool_addr(0), 8'h00);
    // R6 read immediately followed by write
    access(1'b0, pool_addr(3), 8'h00);
    access(1'b1, pool_addr(4), 8'hC3);
    // R8 read value survives an intervening write
    access(1'b0, pool_addr(4), 8'h00);
    held = rdata;
    access(1'b1, pool_addr(7), 8'h3C);
    check(rdata == held, "R8 read data held across write", rdata, held);
    access(1'b1, pool_addr(4), 8'h00);
    check(rdata == held, "R8 read data held after second write", rdata, held);

    for (int n = 0; n < 300; n++) begin
      access($urandom_range(0, 1) == 1, pool_addr($urandom_range(0, 15)), DW'($urandom));
    end
    for (int i = 0; i < 16; i++) access(1'b0, pool_addr(i), 8'h00);

    repeat (4) @(negedge clk);
    check(ce_n && we_n && oe_n && !dq_oe && !done, "R1 idle at end",
          {ce_n, we_n, oe_n, dq_oe, done}, 5'b11100);
    finish_run();
  end

endmodule